// File: doc/BRIEF.md
# Write-Twice Cycle Countdown Interrupt Timer

This block is a 16-bit countdown timer that steps once for every CPU cycle and requests an interrupt when the count passes below zero. Software loads the live count through one register select, using two byte writes that go first to the upper byte and then to the lower byte. A second register select starts or pauses the count. Any write to that select also clears a pending interrupt and returns the byte sequence to the upper byte.

When the count steps from zero, it wraps to all ones. At that point the timer pauses itself and pulls its active-low interrupt line low. The line stays low until the control select is written or the block is reset. Address decoding is done outside the block, which receives only a write strobe, a data byte and two one-hot selects. There is no reload register: every load write lands directly in the running count.

Top module: `cyc_irq_timer`

## Requirements
- R1: After reset `irq_n` is 1, the count is 0x0000, the timer is paused and the next load write targets the upper byte. An enable written straight after reset therefore produces an interrupt on the first enabled CPU cycle.
- R2: Load writes (`wr_en` and `sel_load` high) alternate between bits 15:8 and bits 7:0 of the count, starting with bits 15:8. A third write goes to bits 15:8 again.
- R3: A load write replaces one byte of the live count and leaves the other byte as it was. With count N loaded and counting enabled, `irq_n` falls N+1 enabled CPU cycles after the enabling write.
- R4: A control write (`wr_en` and `sel_ctrl` high) starts counting when `wr_data[4]` is 1 and pauses it when `wr_data[4]` is 0. All other data bits are ignored.
- R5: While counting is enabled, the count drops by one on each clock in which `cpu_ce` is 1. When `cpu_ce` is 0, the count is held.
- R6: On a step from 0x0000 the count becomes 0xFFFF. `irq_n` goes to 0 on that same clock edge, and counting is disabled.
- R7: Once `irq_n` is 0, it stays 0 until a control write or a reset. Load writes do not release it.
- R8: A control write sets `irq_n` to 1 on the next edge and resets the byte sequence, so the next load write goes to bits 15:8.
- R9: A load write on a clock where a count step would also happen takes priority. The written byte is stored and no decrement is applied on that clock.
- R10: A control write on the clock of a wrap takes priority over the wrap. `irq_n` stays 1, and the enable takes the written value of bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_ce | input | 1 | One-clock pulse per CPU cycle; the count steps only when this is high |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write data |
| sel_load | input | 1 | Decoded select for the write-twice count register |
| sel_ctrl | input | 1 | Decoded select for the enable and acknowledge register |
| irq_n | output | 1 | Active-low interrupt request, held until acknowledged |

## Verification
Every state element is a single register, so each write or count step shows its effect one clock edge after the edge that samples it. `irq_n` changes on the same edge that samples the wrapping step, with no extra pipeline stage.

The bench drives inputs just after the falling edge, updates its model at the rising edge and compares `irq_n` at the next falling edge. Each comparison therefore sees exactly the state one edge after the stimulus. Count latencies are checked as an exact number of enabled cycles, N+1 from the enabling write, rather than as a window.

// File: rtl/cyc_irq_timer_pkg.sv
package cyc_irq_timer_pkg;

    // Number of byte lanes in the count: one high byte and one low byte.
    localparam int LANE_CNT = 2;
    localparam int LANE_HI  = 1;
    localparam int LANE_LO  = 0;

    // Sequencer state: which byte the next load write targets.
    typedef struct packed {
        logic hi_next;
    } seq_state_t;

    // Interrupt flag state.
    typedef struct packed {
        logic pend;
    } irq_state_t;

endpackage

// File: rtl/cyc_irq_timer_seq.sv
// Write decoder and byte-toggle sequencer for the load register.
module cyc_irq_timer_seq
    import cyc_irq_timer_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                sel_load,
    input  logic                sel_ctrl,
    output logic [LANE_CNT-1:0] lane_we,
    output logic                ctrl_we,
    output logic                hi_next_o
);

    seq_state_t st_d, st_q;
    logic       load_we;

    always_comb begin
        load_we = wr_en && sel_load;
        ctrl_we = wr_en && sel_ctrl;
        lane_we = '0;
        lane_we[LANE_HI] = load_we && st_q.hi_next;
        lane_we[LANE_LO] = load_we && !st_q.hi_next;

        st_d = st_q;
        if (ctrl_we) begin
            st_d.hi_next = 1'b1;             // ctrl write restarts the sequence
        end else if (load_we) begin
            st_d.hi_next = !st_q.hi_next;    // alternate high / low
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.hi_next <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign hi_next_o = st_q.hi_next;

endmodule

// File: rtl/cyc_irq_timer_count.sv
// Live countdown register with run enable and self-pause on wrap.
module cyc_irq_timer_count
    import cyc_irq_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_ce,
    input  logic [LANE_CNT-1:0] lane_we,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                ctrl_we,
    input  logic                ctrl_run,
    output logic                wrap_o,
    output logic [CNT_W-1:0]    count_o,
    output logic                run_o
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             run;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       step;

    always_comb begin
        // A load write on any lane suppresses the step for this cycle.
        step   = cpu_ce && st_q.run && (lane_we == '0);
        wrap_o = step && (st_q.count == '0);

        st_d = st_q;
        if (step) begin
            st_d.count = st_q.count - ONE;
        end
        for (int i = 0; i < LANE_CNT; i++) begin
            if (lane_we[i]) begin
                st_d.count[i*DATA_W +: DATA_W] = wr_data;
            end
        end

        if (ctrl_we) begin
            st_d.run = ctrl_run;
        end else if (wrap_o) begin
            st_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.count <= '0;
            st_q.run   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;
    assign run_o   = st_q.run;

endmodule

// File: rtl/cyc_irq_timer_irq.sv
// Pending-interrupt flag: set by wrap, cleared by acknowledge (ack wins).
module cyc_irq_timer_irq
    import cyc_irq_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic ack,
    output logic irq_n
);

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ack) begin
            st_d.pend = 1'b0;
        end else if (wrap) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pend <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_n = !st_q.pend;

endmodule

// File: rtl/cyc_irq_timer.sv
// Write-twice cycle countdown interrupt timer, top level.
module cyc_irq_timer
    import cyc_irq_timer_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int DATA_W  = 8,
    parameter int RUN_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_ce,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sel_load,
    input  logic              sel_ctrl,
    output logic              irq_n
);

    logic [LANE_CNT-1:0] lane_we;
    logic                ctrl_we;
    logic                hi_next_w;
    logic                wrap_w;
    logic [CNT_W-1:0]    cnt_w;
    logic                run_w;

    cyc_irq_timer_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .sel_load  (sel_load),
        .sel_ctrl  (sel_ctrl),
        .lane_we   (lane_we),
        .ctrl_we   (ctrl_we),
        .hi_next_o (hi_next_w)
    );

    cyc_irq_timer_count #(
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_ce   (cpu_ce),
        .lane_we  (lane_we),
        .wr_data  (wr_data),
        .ctrl_we  (ctrl_we),
        .ctrl_run (wr_data[RUN_BIT]),
        .wrap_o   (wrap_w),
        .count_o  (cnt_w),
        .run_o    (run_w)
    );

    cyc_irq_timer_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .wrap  (wrap_w),
        .ack   (ctrl_we),
        .irq_n (irq_n)
    );

endmodule

// File: rtl/cyc_irq_timer_chk.sv
// Property checker, bound to the top level.
module cyc_irq_timer_chk #(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ce,
    input logic              wr_en,
    input logic              sel_load,
    input logic              sel_ctrl,
    input logic [DATA_W-1:0] wr_data,
    input logic              irq_n,
    input logic [CNT_W-1:0]  cnt,
    input logic              run,
    input logic              hi_next
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic ldw, cw;
    assign ldw = wr_en && sel_load;
    assign cw  = wr_en && sel_ctrl;

    // R2: each load write without a control write flips the byte target
    assert_toggle_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ldw && !cw) |=> (hi_next != $past(hi_next)));

    // R4: a control write sets the enable to the written bit
    assert_ctrl_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cw |=> (run == $past(wr_data[4])));

    // R5: enabled step without a load write decrements by one
    assert_step_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cpu_ce && !ldw) |=> (cnt == ($past(cnt) - ONE)));

    // R5: paused and not loaded means the count holds
    assert_pause_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ldw) |=> $stable(cnt));

    // R6: wrap without a control write raises the request and disables counting
    assert_wrap_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cpu_ce && !ldw && !cw && cnt == '0) |=> (!irq_n && !run));

    // R6: the request only falls after a wrapping step
    assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(run && cpu_ce && !ldw && cnt == '0));

    // R7: a pending request is held until a control write
    assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !cw) |=> !irq_n);

    // R8: a control write releases the request and restarts the byte sequence
    assert_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cw |=> (irq_n && hi_next));

    // R9: a load write with a step pending applies no decrement to the other byte
    assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ldw && hi_next && run && cpu_ce) |=> (cnt[DATA_W-1:0] == $past(cnt[DATA_W-1:0])));

endmodule

bind cyc_irq_timer cyc_irq_timer_chk #(
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_ce   (cpu_ce),
    .wr_en    (wr_en),
    .sel_load (sel_load),
    .sel_ctrl (sel_ctrl),
    .wr_data  (wr_data),
    .irq_n    (irq_n),
    .cnt      (cnt_w),
    .run      (run_w),
    .hi_next  (hi_next_w)
);

// File: tb/tb_cyc_irq_timer.sv
module tb_cyc_irq_timer;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_ce = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       sel_load = 1'b0;
    logic       sel_ctrl = 1'b0;
    logic       irq_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference state, updated from the requirements
    logic [15:0] m_cnt;
    logic        m_run, m_hi, m_pend;

    always #(CLK_PERIOD/2) clk = ~clk;

    cyc_irq_timer dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_ce   (cpu_ce),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .sel_load (sel_load),
        .sel_ctrl (sel_ctrl),
        .irq_n    (irq_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] next_cnt(input logic [15:0] c, input logic ld,
                                             input logic hi, input logic [7:0] d,
                                             input logic stp);
        logic [15:0] r;
        r = c;
        if (ld) begin
            if (hi) r[15:8] = d; else r[7:0] = d;
        end else if (stp) begin
            r = c - 16'd1;
        end
        return r;
    endfunction

    task automatic model_edge();
        logic ldw, cw, stp, wrp;
        ldw = wr_en && sel_load;
        cw  = wr_en && sel_ctrl;
        stp = cpu_ce && m_run && !ldw;
        wrp = stp && (m_cnt == 16'h0000);
        m_cnt = next_cnt(m_cnt, ldw, m_hi, wr_data, stp);
        if (cw) m_hi = 1'b1; else if (ldw) m_hi = !m_hi;
        if (cw) m_run = wr_data[4]; else if (wrp) m_run = 1'b0;
        if (cw) m_pend = 1'b0; else if (wrp) m_pend = 1'b1;
    endtask

    // one clock: drive, edge, model, compare at the falling edge
    task automatic step(input logic ce, input logic we, input logic sl,
                        input logic sc, input logic [7:0] d, input string tag);
        cpu_ce = ce; wr_en = we; sel_load = sl; sel_ctrl = sc; wr_data = d;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(irq_n == !m_pend, tag, int'(irq_n), int'(!m_pend));
        cpu_ce = 1'b0; wr_en = 1'b0; sel_load = 1'b0; sel_ctrl = 1'b0;
    endtask

    task automatic wr_load(input logic [7:0] d, input string tag);
        step(1'b1, 1'b1, 1'b1, 1'b0, d, tag);
    endtask

    task automatic wr_ctrl(input logic [7:0] d, input string tag);
        step(1'b1, 1'b1, 1'b0, 1'b1, d, tag);
    endtask

    // enabled cycles from now until irq_n falls
    task automatic measure(output int n, input int limit, input string tag);
        n = 0;
        while (irq_n && n < limit) begin
            step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, tag);
            n++;
        end
    endtask

    initial begin : main
        int lat;
        m_cnt = 16'h0; m_run = 1'b0; m_hi = 1'b1; m_pend = 1'b0;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(irq_n == 1'b1, "R1 reset irq_n", int'(irq_n), 1);

        // R1: count is zero after reset, so enable wraps on first cycle
        wr_ctrl(8'h10, "R1 enable");
        measure(lat, 10, "R1 run");
        chk(lat == 1, "R1 wrap from reset count", lat, 1);
        wr_ctrl(8'h00, "R8 ack");
        chk(irq_n == 1'b1, "R8 ack releases irq", int'(irq_n), 1);

        // R2/R3: high then low, latency N+1
        wr_load(8'h00, "R2 hi"); wr_load(8'h03, "R2 lo");
        wr_ctrl(8'h10, "R3 enable");
        measure(lat, 100, "R3 run");
        chk(lat == 4, "R3 latency count 3", lat, 4);

        // R2: third write targets high byte again
        wr_ctrl(8'h00, "R8 ack");
        wr_load(8'h01, "R2 w1"); wr_load(8'h02, "R2 w2"); wr_load(8'h00, "R2 w3");
        wr_ctrl(8'h10, "R2 enable");
        measure(lat, 1000, "R2 run");
        chk(lat == 3, "R2 third write to high byte", lat, 3);

        // R8: control write resets the toggle
        wr_ctrl(8'h00, "R8 ack");
        wr_load(8'h05, "R8 hi");
        wr_ctrl(8'h00, "R8 toggle reset");
        wr_load(8'h00, "R8 hi again"); wr_load(8'h04, "R8 lo");
        wr_ctrl(8'h10, "R8 enable");
        measure(lat, 2000, "R8 run");
        chk(lat == 5, "R8 toggle reset latency", lat, 5);

        // R4: other data bits ignored, bit 4 clear pauses
        wr_ctrl(8'h00, "R4 ack");
        wr_load(8'h00, "R4 hi"); wr_load(8'h02, "R4 lo");
        wr_ctrl(8'hEF, "R4 pause with other bits set");
        repeat (10) step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R4 paused");
        chk(irq_n == 1'b1, "R4 no irq while paused", int'(irq_n), 1);
        wr_ctrl(8'h10, "R4 enable");
        measure(lat, 100, "R4 run");
        chk(lat == 3, "R4 count held during pause", lat, 3);

        // R5: cpu_ce gating
        wr_ctrl(8'h00, "R5 ack");
        wr_load(8'h00, "R5 hi"); wr_load(8'h04, "R5 lo");
        wr_ctrl(8'h10, "R5 enable");
        lat = 0;
        for (int i = 0; i < 40 && irq_n; i++) begin
            step(1'(i % 2), 1'b0, 1'b0, 1'b0, 8'h00, "R5 gated");
            if (i % 2 == 1) lat++;
        end
        chk(lat == 5, "R5 only ce cycles count", lat, 5);

        // R7: held through idle cycles and load writes
        repeat (20) step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R7 hold");
        wr_load(8'h00, "R7 load during pending");
        chk(irq_n == 1'b0, "R7 irq held", int'(irq_n), 0);

        // R9: load write beats a count step
        wr_ctrl(8'h00, "R9 ack");
        wr_load(8'h00, "R9 hi"); wr_load(8'h10, "R9 lo");
        wr_ctrl(8'h10, "R9 enable");
        repeat (3) step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R9 run");
        wr_load(8'h00, "R9 hi while running");
        wr_load(8'h06, "R9 lo while running");
        measure(lat, 100, "R9 run");
        chk(lat == 7, "R9 no decrement on load cycle", lat, 7);

        // R10: control write in the wrap cycle wins
        wr_ctrl(8'h00, "R10 ack");
        wr_load(8'h00, "R10 hi"); wr_load(8'h02, "R10 lo");
        wr_ctrl(8'h10, "R10 enable");
        repeat (2) step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R10 run");
        wr_ctrl(8'h10, "R10 ctrl on wrap");
        chk(irq_n == 1'b1, "R10 ack beats wrap", int'(irq_n), 1);
        wr_load(8'h00, "R10 hi"); wr_load(8'h02, "R10 lo");
        measure(lat, 100, "R10 still running");
        chk(lat == 3, "R10 enable kept from write", lat, 3);

        // random phase checked every cycle against the model (R2 R5 R6 R7 R9)
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [7:0] d;
            r = int'($urandom_range(0, 99));
            d = 8'($urandom_range(0, 255));
            if (r < 8) begin
                step(1'($urandom_range(0, 1)), 1'b1, 1'b1, 1'b0,
                     m_hi ? 8'($urandom_range(0, 1)) : d, "R9 random load");
            end else if (r < 13) begin
                step(1'($urandom_range(0, 1)), 1'b1, 1'b0, 1'b1, d, "R6 random ctrl");
            end else begin
                step(1'($urandom_range(0, 3) != 0), 1'b0, 1'b0, 1'b0, d, "R7 random idle");
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule